// File: doc/BRIEF.md
# BCD Calendar Clock Register File

This block keeps calendar time as packed BCD bytes and shows it to a host through a byte-addressed register file. It counts seconds, minutes, hours, weekday, day of month, month and a two-digit year, where year YY stands for 20YY. A 1 Hz tick input drives the counting, and the day of month rolls over according to the length of each month, with leap Februaries. Alongside the time it holds five alarm bytes and a flags byte. The alarm flag rises when an enabled alarm matches the clock.

The host sees a plain synchronous register port. Writes take effect on the clock edge. Reads return registered data one cycle after the read strobe. A stop bit in the seconds byte pauses timekeeping. A battery-standby entry strobe sets a halt-update bit in the alarm-hour byte. While that bit is set, host reads of the time bytes return a frozen copy and the live counters keep running. Writing the bit back to 0 makes the live time visible again.

Top module: `rtc_regfile`

## Requirements
- R1: `rd_data` takes the addressed byte on the edge where `rd_en` is 1 and holds its value otherwise. Address 0 (hundredths) and the unmapped addresses 8 and 9 read 0x00. Out of reset the clock reads 00:00:00, weekday 1, day 01, month 01, year 00, and the alarm bytes and flags read 0x00.
- R2: A write to a time byte replaces only its writable bits and keeps the rest. The writable masks are seconds 0xFF (bit 7 is the stop bit), minutes 0x7F, hours 0x3F, weekday 0x07, day 0x3F, month 0x1F and year 0xFF. A write to address 0 has no effect.
- R3: While seconds bit 7 is 1, ticks do not advance the time. A tick that arrives in the same cycle as a host write to any of addresses 1 to 7 is dropped.
- R4: Each tick advances the seconds in BCD. 59 wraps to 00 and carries into the minutes. Minutes carry into the hours, which wrap 23 to 00. The hour wrap advances the day and the weekday, and the weekday (binary) wraps from 7 to 1.
- R5: The day wraps to 01 past the month's last day: 30 for months 04, 06, 09 and 11, 31 for the others, and for 02 29 when the year value is divisible by 4 and 28 otherwise. The day wrap advances the month. Month 12 wraps to 01 and advances the year, and year 99 wraps to 00.
- R6: `standby_enter` sets bit 6 of the alarm-hour byte (address 0xC). While that bit is 1, reads of addresses 1 to 7 return the values held when it was set, and ticks and writes still act on the live time. Writing the bit to 0 makes reads return the live time.
- R7: The alarm bytes sit at 0xA (month; bit 7 enable, bit 6 stored only), 0xB (day), 0xC (hour), 0xD (minute) and 0xE (second). When a tick has advanced the time and alarm is enabled, the flag (address 0xF bit 6) sets if month[4:0], day[5:0], hour[5:0], minute[6:0] and second[6:0] all equal the alarm bytes.
- R8: A read of address 0xF clears the alarm flag after returning it, and a set in the same cycle wins. Writes to 0xF have no effect.
- R9: Flags bit 4 shows `batt_low`, registered once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| standby_enter | input | 1 | Pulse when battery standby is entered |
| batt_low | input | 1 | Battery-low level |
| addr | input | ADDR_W | Register address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |

## Verification
The bench walks the calendar across its carry edges: the full 23:59:59 on 31 Dec 99 wrap, BCD digit carries, leap and plain Februaries, and 30- and 31-day months. A wrong month-length or leap decode shows up as a day 29, 30 or 31 that should not exist, or as one that is skipped. It freezes the visible time with the standby strobe and then ticks and writes underneath. A design that froze the live counters, or refreshed the copy, would read back the wrong seconds and minutes after the halt bit is cleared. It also covers the stop bit, a tick that collides with a write, a disabled or mismatched alarm and the clear-on-read of the flag, each of which leaves a wrong byte at the port when done wrong.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned TIME_REGS  = 8;
  localparam int unsigned ALARM_REGS = 5;

  localparam logic [3:0] A_HSEC  = 4'h0;
  localparam logic [3:0] A_SEC   = 4'h1;
  localparam logic [3:0] A_MIN   = 4'h2;
  localparam logic [3:0] A_HOUR  = 4'h3;
  localparam logic [3:0] A_WDAY  = 4'h4;
  localparam logic [3:0] A_DAY   = 4'h5;
  localparam logic [3:0] A_MON   = 4'h6;
  localparam logic [3:0] A_YEAR  = 4'h7;
  localparam logic [3:0] A_AMON  = 4'hA;
  localparam logic [3:0] A_FLAGS = 4'hF;

  localparam int unsigned SEC_STOP_BIT = 7;
  localparam int unsigned ALM_EN_BIT   = 7;
  localparam int unsigned HALT_BIT     = 6;
  localparam int unsigned FLG_AF_BIT   = 6;
  localparam int unsigned FLG_BL_BIT   = 4;
  localparam int unsigned ALM_HOUR_IDX = 2;

  // Bits a host write may change in each time byte
  function automatic logic [7:0] field_mask(input int idx);
    case (idx)
      1:       return 8'hFF;
      2:       return 8'h7F;
      3:       return 8'h3F;
      4:       return 8'h07;
      5:       return 8'h3F;
      6:       return 8'h1F;
      7:       return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  // Bits compared by the alarm, index 0 = month .. 4 = second
  function automatic logic [7:0] alarm_mask(input int idx);
    case (idx)
      0:       return 8'h1F;
      1:       return 8'h3F;
      2:       return 8'h3F;
      default: return 8'h7F;
    endcase
  endfunction

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [7:0] month_days(input logic [7:0] mon, input logic [7:0] yr);
    logic [6:0] ybin;
    ybin = 7'(yr[7:4]) * 7'd10 + 7'(yr[3:0]);
    case (mon)
      8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [7:0]                   wr_data,
  output logic [TIME_REGS-1:0][7:0]    live_q,
  output logic                         adv_q
);
  localparam logic [TIME_REGS-1:0][7:0] RESET_TIME =
    {8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

  logic [TIME_REGS-1:0]      hit;
  logic [TIME_REGS-1:0][7:0] nxt;
  logic                      any_wr, step;
  logic [7:0] sec_f, min_f, hour_f, day_f, mon_f, year_f, mdays;
  logic [2:0] wd_f;
  logic       c_sec, c_min, c_hour, c_day, c_mon;

  assign hit[0] = 1'b0;
  for (genvar g = 1; g < TIME_REGS; g++) begin : g_hit
    assign hit[g] = wr_en && (addr == ADDR_W'(g));
  end

  assign any_wr = |hit;
  assign step   = tick && !live_q[A_SEC][SEC_STOP_BIT] && !any_wr;

  assign sec_f  = {1'b0, live_q[A_SEC][6:0]};
  assign min_f  = {1'b0, live_q[A_MIN][6:0]};
  assign hour_f = {2'b0, live_q[A_HOUR][5:0]};
  assign day_f  = {2'b0, live_q[A_DAY][5:0]};
  assign mon_f  = {3'b0, live_q[A_MON][4:0]};
  assign year_f = live_q[A_YEAR];
  assign wd_f   = live_q[A_WDAY][2:0];
  assign mdays  = month_days(mon_f, year_f);

  assign c_sec  = sec_f >= 8'h59;
  assign c_min  = c_sec && (min_f >= 8'h59);
  assign c_hour = c_min && (hour_f >= 8'h23);
  assign c_day  = c_hour && (day_f >= mdays);
  assign c_mon  = c_day && (mon_f >= 8'h12);

  always_comb begin
    nxt = live_q;
    for (int i = 1; i < TIME_REGS; i++) begin
      if (hit[i]) nxt[i] = (live_q[i] & ~field_mask(i)) | (wr_data & field_mask(i));
    end
    if (step) begin
      nxt[A_SEC][6:0] = c_sec ? 7'h00 : bcd_inc(sec_f)[6:0];
      if (c_sec)  nxt[A_MIN][6:0]  = c_min ? 7'h00 : bcd_inc(min_f)[6:0];
      if (c_min)  nxt[A_HOUR][5:0] = c_hour ? 6'h00 : bcd_inc(hour_f)[5:0];
      if (c_hour) begin
        nxt[A_WDAY][2:0] = (wd_f == 3'd7) ? 3'd1 : wd_f + 3'd1;
        nxt[A_DAY][5:0]  = c_day ? 6'h01 : bcd_inc(day_f)[5:0];
      end
      if (c_day)  nxt[A_MON][4:0] = c_mon ? 5'h01 : bcd_inc(mon_f)[4:0];
      if (c_mon)  nxt[A_YEAR]     = (year_f >= 8'h99) ? 8'h00 : bcd_inc(year_f);
    end
    nxt[A_HSEC] = 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= RESET_TIME;
      adv_q  <= 1'b0;
    end else begin
      live_q <= nxt;
      adv_q  <= step;
    end
  end
endmodule

// File: rtl/rtc_alarm_unit.sv
module rtc_alarm_unit
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [7:0]                    wr_data,
  input  logic                          standby,
  input  logic                          adv,
  input  logic [ALARM_REGS-1:0][7:0]    cur,
  output logic [ALARM_REGS-1:0][7:0]    alm_q,
  output logic                          af_q,
  output logic                          halt
);
  logic [ALARM_REGS-1:0]      hit, eq;
  logic [ALARM_REGS-1:0][7:0] nxt;
  logic                       af_set, af_clr;

  for (genvar g = 0; g < ALARM_REGS; g++) begin : g_alm
    assign hit[g] = wr_en && (addr == ADDR_W'(A_AMON) + ADDR_W'(g));
    assign eq[g]  = ((alm_q[g] ^ cur[g]) & alarm_mask(g)) == 8'h00;
  end

  always_comb begin
    nxt = alm_q;
    for (int i = 0; i < ALARM_REGS; i++) begin
      if (hit[i]) nxt[i] = wr_data;
    end
    if (standby) nxt[ALM_HOUR_IDX][HALT_BIT] = 1'b1;
  end

  assign af_set = adv && alm_q[0][ALM_EN_BIT] && (&eq);
  assign af_clr = rd_en && (addr == ADDR_W'(A_FLAGS));
  assign halt   = alm_q[ALM_HOUR_IDX][HALT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      alm_q <= '0;
      af_q  <= 1'b0;
    end else begin
      alm_q <= nxt;
      if (af_set)      af_q <= 1'b1;
      else if (af_clr) af_q <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_1hz,
  input  logic              standby_enter,
  input  logic              batt_low,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [7:0]        wr_data,
  input  logic              rd_en,
  output logic [7:0]        rd_data
);
  logic [TIME_REGS-1:0][7:0]  live_q, snap_q, vis;
  logic [ALARM_REGS-1:0][7:0] alm_q, cur;
  logic                       adv, af_q, halt, bl_q;
  logic [7:0]                 rd_mux;

  rtc_time_core #(.ADDR_W(ADDR_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick_1hz), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .live_q(live_q), .adv_q(adv)
  );

  assign cur = {live_q[A_SEC], live_q[A_MIN], live_q[A_HOUR], live_q[A_DAY], live_q[A_MON]};

  rtc_alarm_unit #(.ADDR_W(ADDR_W)) u_alarm (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .standby(standby_enter), .adv(adv), .cur(cur),
    .alm_q(alm_q), .af_q(af_q), .halt(halt)
  );

  // Copy follows the live time until halt-update is set, then holds
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_q <= '0;
      bl_q   <= 1'b0;
    end else begin
      if (!halt) snap_q <= live_q;
      bl_q <= batt_low;
    end
  end

  assign vis = halt ? snap_q : live_q;

  always_comb begin
    rd_mux = 8'h00;
    for (int i = 1; i < TIME_REGS; i++) begin
      if (addr == ADDR_W'(i)) rd_mux = vis[i];
    end
    for (int j = 0; j < ALARM_REGS; j++) begin
      if (addr == ADDR_W'(A_AMON) + ADDR_W'(j)) rd_mux = alm_q[j];
    end
    if (addr == ADDR_W'(A_FLAGS)) begin
      rd_mux[FLG_AF_BIT] = af_q;
      rd_mux[FLG_BL_BIT] = bl_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= 8'h00;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/rtc_regfile_chk.sv
module rtc_regfile_chk #(
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              standby,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [63:0]       live,
  input logic [63:0]       snap,
  input logic              halt,
  input logic              af,
  input logic              afe,
  input logic              adv,
  input logic [7:0]        rd_data
);
  logic wr_time, stop;
  assign wr_time = wr_en && (addr >= ADDR_W'(1)) && (addr <= ADDR_W'(7));
  assign stop    = live[15];

  p_rd_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));

  p_stop_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (stop && !wr_time) |=> $stable(live));

  p_adv_source_r3: assert property (@(posedge clk) disable iff (rst)
    adv |-> ($past(tick) && !$past(stop) && !$past(wr_time)));

  p_standby_halt_r6: assert property (@(posedge clk) disable iff (rst)
    standby |=> halt);

  p_halt_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    (halt && $past(halt)) |-> $stable(snap));

  p_af_cause_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(af) |-> ($past(adv) && $past(afe)));

  p_af_clear_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(af) |-> $past(rd_en && (addr == ADDR_W'(15))));
endmodule

bind rtc_regfile rtc_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .tick(tick_1hz), .standby(standby_enter),
  .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .live(live_q), .snap(snap_q),
  .halt(halt), .af(af_q), .afe(alm_q[0][7]), .adv(adv), .rd_data(rd_data)
);

// File: tb/rtc_regfile_tb.sv
module rtc_regfile_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_1hz = 1'b0, standby_enter = 1'b0, batt_low = 1'b0;
  logic [3:0] addr = 4'h0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_regfile #(.ADDR_W(4)) u_dut (
    .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .standby_enter(standby_enter),
    .batt_low(batt_low), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data)
  );

  // {req, kind (1 write, 2 read), addr, wdata, expected}
  localparam int NV = 28;
  localparam logic [27:0] VEC [NV] = '{
    {4'd1, 4'd2, 4'h0, 8'h00, 8'h00},  // R1 hundredths
    {4'd1, 4'd2, 4'h1, 8'h00, 8'h00},  // R1 seconds
    {4'd1, 4'd2, 4'h2, 8'h00, 8'h00},  // R1 minutes
    {4'd1, 4'd2, 4'h3, 8'h00, 8'h00},  // R1 hours
    {4'd1, 4'd2, 4'h4, 8'h00, 8'h01},  // R1 weekday
    {4'd1, 4'd2, 4'h5, 8'h00, 8'h01},  // R1 day
    {4'd1, 4'd2, 4'h6, 8'h00, 8'h01},  // R1 month
    {4'd1, 4'd2, 4'h7, 8'h00, 8'h00},  // R1 year
    {4'd1, 4'd2, 4'hF, 8'h00, 8'h00},  // R1 flags
    {4'd1, 4'd2, 4'h8, 8'h00, 8'h00},  // R1 unmapped
    {4'd2, 4'd1, 4'h3, 8'hFF, 8'h00},  // R2
    {4'd2, 4'd2, 4'h3, 8'h00, 8'h3F},  // R2 hours mask
    {4'd2, 4'd1, 4'h4, 8'hFF, 8'h00},  // R2
    {4'd2, 4'd2, 4'h4, 8'h00, 8'h07},  // R2 weekday mask
    {4'd2, 4'd1, 4'h6, 8'hFF, 8'h00},  // R2
    {4'd2, 4'd2, 4'h6, 8'h00, 8'h1F},  // R2 month mask
    {4'd2, 4'd1, 4'h2, 8'hFF, 8'h00},  // R2
    {4'd2, 4'd2, 4'h2, 8'h00, 8'h7F},  // R2 minutes mask
    {4'd2, 4'd1, 4'h7, 8'h99, 8'h00},  // R2
    {4'd2, 4'd2, 4'h7, 8'h00, 8'h99},  // R2 year full byte
    {4'd2, 4'd1, 4'h0, 8'h55, 8'h00},  // R2 write to hundredths
    {4'd2, 4'd2, 4'h0, 8'h00, 8'h00},  // R2 hundredths unchanged
    {4'd8, 4'd1, 4'hF, 8'hFF, 8'h00},  // R8 flags write
    {4'd8, 4'd2, 4'hF, 8'h00, 8'h00},  // R8 flags unchanged
    {4'd7, 4'd1, 4'hA, 8'hC5, 8'h00},  // R7
    {4'd7, 4'd2, 4'hA, 8'h00, 8'hC5},  // R7 enable and stored bit 6
    {4'd6, 4'd1, 4'hC, 8'h23, 8'h00},  // R6
    {4'd6, 4'd2, 4'hC, 8'h00, 8'h23}   // R6 alarm-hour readback
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic chk_reg(input logic [3:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick_1hz = 1'b1;
    @(negedge clk); tick_1hz = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_time(input logic [7:0] y, mo, d, w, h, mi, s);
    wr(4'h7, y); wr(4'h6, mo); wr(4'h5, d); wr(4'h4, w);
    wr(4'h3, h); wr(4'h2, mi); wr(4'h1, s);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][23:20] == 4'd1) wr(VEC[i][19:16], VEC[i][15:8]);
      else begin
        rd(VEC[i][19:16], v);
        chk($sformatf("R%0d vector %0d", VEC[i][27:24], i), v, VEC[i][7:0]);
      end
    end
    wr(4'hA, 8'h00);

    // R4 R5 full rollover at end of century
    set_time(8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    chk_reg(4'h1, 8'h00, "R4 sec wrap");
    chk_reg(4'h2, 8'h00, "R4 min wrap");
    chk_reg(4'h3, 8'h00, "R4 hour wrap");
    chk_reg(4'h4, 8'h01, "R4 weekday 7 to 1");
    chk_reg(4'h5, 8'h01, "R5 day wrap");
    chk_reg(4'h6, 8'h01, "R5 month wrap");
    chk_reg(4'h7, 8'h00, "R5 year wrap");

    // R4 BCD digit carry and minute carry
    set_time(8'h24, 8'h03, 8'h15, 8'h03, 8'h10, 8'h29, 8'h09);
    pulse_tick();
    chk_reg(4'h1, 8'h10, "R4 sec digit carry");
    chk_reg(4'h2, 8'h29, "R4 min held");
    chk_reg(4'h4, 8'h03, "R4 weekday held");
    wr(4'h1, 8'h59);
    pulse_tick();
    chk_reg(4'h1, 8'h00, "R4 sec 59 wrap");
    chk_reg(4'h2, 8'h30, "R4 min carry");
    chk_reg(4'h3, 8'h10, "R4 hour held");

    // R5 leap February
    set_time(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    chk_reg(4'h5, 8'h29, "R5 leap day 29");
    chk_reg(4'h6, 8'h02, "R5 leap month held");
    wr(4'h3, 8'h23); wr(4'h2, 8'h59); wr(4'h1, 8'h59);
    pulse_tick();
    chk_reg(4'h5, 8'h01, "R5 leap end day");
    chk_reg(4'h6, 8'h03, "R5 leap end month");

    // R5 plain February, 30- and 31-day months
    set_time(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    chk_reg(4'h5, 8'h01, "R5 plain Feb day");
    chk_reg(4'h6, 8'h03, "R5 plain Feb month");
    set_time(8'h23, 8'h04, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    chk_reg(4'h5, 8'h01, "R5 30-day month day");
    chk_reg(4'h6, 8'h05, "R5 30-day month month");
    set_time(8'h23, 8'h05, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    pulse_tick();
    chk_reg(4'h5, 8'h31, "R5 31-day month day");

    // R3 stop bit and tick colliding with write
    set_time(8'h23, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00);
    wr(4'h1, 8'h90);
    pulse_tick();
    chk_reg(4'h1, 8'h90, "R3 stopped");
    wr(4'h1, 8'h10);
    pulse_tick();
    chk_reg(4'h1, 8'h11, "R3 running again");
    @(negedge clk);
    addr = 4'h1; wr_data = 8'h30; wr_en = 1'b1; tick_1hz = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_1hz = 1'b0;
    chk_reg(4'h1, 8'h30, "R3 tick dropped on write");

    // R6 halt-update freeze
    set_time(8'h23, 8'h06, 8'h15, 8'h04, 8'h12, 8'h00, 8'h20);
    @(negedge clk); standby_enter = 1'b1;
    @(negedge clk); standby_enter = 1'b0;
    chk_reg(4'hC, 8'h63, "R6 halt bit set");
    pulse_tick();
    pulse_tick();
    chk_reg(4'h1, 8'h20, "R6 seconds frozen");
    wr(4'h2, 8'h45);
    chk_reg(4'h2, 8'h00, "R6 minutes frozen");
    wr(4'hC, 8'h23);
    chk_reg(4'h1, 8'h22, "R6 live seconds");
    chk_reg(4'h2, 8'h45, "R6 live minutes");

    // R7 R8 alarm
    wr(4'hA, 8'h06); wr(4'hB, 8'h15); wr(4'hC, 8'h12);
    wr(4'hD, 8'h30); wr(4'hE, 8'h00);
    set_time(8'h23, 8'h06, 8'h15, 8'h04, 8'h12, 8'h29, 8'h59);
    pulse_tick();
    chk_reg(4'hF, 8'h00, "R7 alarm disabled");
    wr(4'hA, 8'h86);
    set_time(8'h23, 8'h06, 8'h15, 8'h04, 8'h12, 8'h29, 8'h59);
    pulse_tick();
    chk_reg(4'hF, 8'h40, "R7 alarm match");
    chk_reg(4'hF, 8'h00, "R8 cleared by read");
    set_time(8'h23, 8'h07, 8'h15, 8'h04, 8'h12, 8'h29, 8'h59);
    pulse_tick();
    chk_reg(4'hF, 8'h00, "R7 month mismatch");

    // R9 battery low
    @(negedge clk); batt_low = 1'b1;
    chk_reg(4'hF, 8'h10, "R9 battery low set");
    @(negedge clk); batt_low = 1'b0;
    chk_reg(4'hF, 8'h00, "R9 battery low clear");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule